// File: doc/BRIEF.md
# Prioritised Multi-Target Interrupt Controller

This block collects a set of level-sensitive interrupt lines and presents them to several processor contexts. Every source carries a programmable urgency level. Each context has its own mask of sources and its own minimum urgency. Each context also has one request output, which stays high while some source is waiting that the context accepts. Software works the block through a 32-bit, single-cycle, word-addressed register port.

A context services an interrupt by reading its claim register. That read returns the identifier of the most urgent acceptable source, ties going to the lower identifier. In the same cycle the source's waiting flag is cleared and the source is held off. Software writes the identifier back to the same register when service is done. That releases the source, so its line may raise it again. Identifier 0 is reserved for "nothing to service".

Top module: `irqc_top`

## Requirements
- R1: After reset every urgency level, mask bit, context minimum and waiting flag reads 0, no source is held off, every request output is low and a claim read returns 0.
- R2: The urgency level of source ID (1..NUM_SRC) sits at word address ID (byte 4×ID). Writes keep the low PRIO_W bits and reads return them zero-extended. Word address 0 is not a register.
- R3: The waiting flags are read at word address 0x400 (byte 0x1000), with source ID at bit ID and bit 0 always 0. Writes there have no effect. A flag sets on a clock edge where the line is high and the source is not held off, and it stays set after the line drops, until the source is claimed.
- R4: The mask of context T sits at word address 0x800 + 0x20×T (byte 0x2000 + 0x80×T), with source ID at bit ID and bit 0 always 0. Each context's mask is independent of the others.
- R5: The minimum of context T sits at word address 0x80000 + 0x400×T (byte 0x200000 + 0x1000×T). A source is eligible for T when it is waiting, unmasked for T, and its level is strictly above T's minimum. Request output T is high exactly when T has an eligible source.
- R6: A read of the claim register of context T at word address 0x80001 + 0x400×T (byte 0x200004 + 0x1000×T) returns the ID of T's eligible source with the highest level, the lowest ID among equals, or 0 when none is eligible.
- R7: A claim read that returns a nonzero ID clears that source's waiting flag and holds the source off. While held off, its flag stays 0 even with the line high.
- R8: Writing ID to the claim register of context T releases a held-off source only when 1 ≤ ID ≤ NUM_SRC and the source is unmasked for T. Any other write value changes nothing.
- R9: Reads of any address that is not a register return 0.
- R10: A claim read that returns 0 leaves every waiting flag and hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| irqIn | input | NUM_SRC (NUM_SRC:1) | Level interrupt lines, bit ID for source ID |
| irqOut | output | NUM_TGT | Request output per context |

## Verification
The hardest state to reach from the ports is a held-off source whose line is still high. Only the waiting-flag word shows it, because the request output and the claim read are already quiet. The bench raises every line, drains both contexts by claiming without completing, and then holds the lines high across idle cycles. It then sends completions with ID 0, with an out-of-range ID and through a context whose mask lacks the source, and reads the waiting word after each one. Then a proper completion must bring the flag back. A per-source sweep also drives each line alone, with two urgency patterns and a sweep of context minimums, and checks every claim against a bench-side model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Word-address map (byte address / 4)
  localparam int unsigned PEND_WBASE  = 32'h0000_0400;
  localparam int unsigned EN_WBASE    = 32'h0000_0800;
  localparam int unsigned EN_WSTRIDE  = 32'h0000_0020;
  localparam int unsigned CTX_WBASE   = 32'h0008_0000;
  localparam int unsigned CTX_WSTRIDE = 32'h0000_0400;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PRIO,
    RD_PEND,
    RD_EN,
    RD_THR,
    RD_CLAIM
  } rdKind_e;

  typedef struct packed {
    logic    prioWe;
    logic    enWe;
    logic    thrWe;
    logic    claimRe;
    logic    cmplWe;
    rdKind_e rdKind;
  } strobes_t;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_TGT = 2,
  parameter int ADDR_W  = 20,
  parameter int SRC_W   = 5,
  parameter int TGT_W   = 1,
  parameter int WORD_W  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          strb,
  output logic [SRC_W-1:0]  srcIdx,
  output logic [TGT_W-1:0]  tgtIdx,
  output logic [WORD_W-1:0] wordIdx
);

  localparam int NUM_WORDS = (NUM_SRC + 32) / 32;

  logic [31:0] wordAddr;
  logic [31:0] offs;
  logic        hitPrio, hitPend, hitEn, hitThr, hitClaim;
  logic        doWr, doRd;

  assign wordAddr = 32'(busAddr);
  assign doWr     = busSel && busWe;
  assign doRd     = busSel && !busWe;

  always_comb begin
    hitPrio  = 1'b0;
    hitPend  = 1'b0;
    hitEn    = 1'b0;
    hitThr   = 1'b0;
    hitClaim = 1'b0;
    offs     = '0;
    srcIdx   = '0;
    tgtIdx   = '0;
    wordIdx  = '0;
    if (wordAddr >= 32'd1 && wordAddr <= 32'(NUM_SRC)) begin
      hitPrio = 1'b1;
      srcIdx  = wordAddr[SRC_W-1:0];
    end else if (wordAddr >= PEND_WBASE && wordAddr < PEND_WBASE + 32'(NUM_WORDS)) begin
      hitPend = 1'b1;
      wordIdx = WORD_W'(wordAddr - PEND_WBASE);
    end else if (wordAddr >= EN_WBASE &&
                 wordAddr < EN_WBASE + 32'(NUM_TGT) * EN_WSTRIDE) begin
      offs = wordAddr - EN_WBASE;
      if ((offs % EN_WSTRIDE) < 32'(NUM_WORDS)) begin
        hitEn   = 1'b1;
        tgtIdx  = TGT_W'(offs / EN_WSTRIDE);
        wordIdx = WORD_W'(offs % EN_WSTRIDE);
      end
    end else if (wordAddr >= CTX_WBASE &&
                 wordAddr < CTX_WBASE + 32'(NUM_TGT) * CTX_WSTRIDE) begin
      offs   = wordAddr - CTX_WBASE;
      tgtIdx = TGT_W'(offs / CTX_WSTRIDE);
      hitThr   = (offs % CTX_WSTRIDE) == 32'd0;
      hitClaim = (offs % CTX_WSTRIDE) == 32'd1;
    end
  end

  always_comb begin
    strb.prioWe  = doWr && hitPrio;
    strb.enWe    = doWr && hitEn;
    strb.thrWe   = doWr && hitThr;
    strb.cmplWe  = doWr && hitClaim;
    strb.claimRe = doRd && hitClaim;
    strb.rdKind  = RD_NONE;
    if (doRd) begin
      if (hitPrio)       strb.rdKind = RD_PRIO;
      else if (hitPend)  strb.rdKind = RD_PEND;
      else if (hitEn)    strb.rdKind = RD_EN;
      else if (hitThr)   strb.rdKind = RD_THR;
      else if (hitClaim) strb.rdKind = RD_CLAIM;
    end
  end

  // R9: decoded regions never overlap, so at most one action per access
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.prioWe, strb.enWe, strb.thrWe, strb.claimRe, strb.cmplWe}));

  // R9: a write never selects read data
  assert_write_no_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe) |-> (strb.rdKind == RD_NONE));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int SRC_W   = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SRC:1]               elig,
  input  logic [NUM_SRC:1][PRIO_W-1:0]   prioVec,
  input  logic [PRIO_W-1:0]              thr,
  output logic [SRC_W-1:0]               winId,
  output logic                           winValid
);

  logic [PRIO_W-1:0] bestPrio;

  // Ascending scan with strict compare: equal levels keep the lower ID
  always_comb begin
    winId    = '0;
    winValid = 1'b0;
    bestPrio = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (elig[i] && (prioVec[i] > thr) && (!winValid || prioVec[i] > bestPrio)) begin
        winValid = 1'b1;
        winId    = SRC_W'(i);
        bestPrio = prioVec[i];
      end
    end
  end

  assert_win_eligible_R5: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (elig[winId] && (prioVec[winId] > thr)));

  assert_idle_id_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |-> (winId == '0));

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_TGT = 2,
  parameter int PRIO_W  = 3,
  parameter int SRC_W   = 5,
  parameter int TGT_W   = 1,
  parameter int WORD_W  = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [SRC_W-1:0]   srcIdx,
  input  logic [TGT_W-1:0]   tgtIdx,
  input  logic [WORD_W-1:0]  wordIdx,
  input  logic [31:0]        wdata,
  input  logic [NUM_SRC:1]   irqIn,
  output logic [31:0]        rdata,
  output logic [NUM_TGT-1:0] irqOut
);

  logic [NUM_SRC:1][PRIO_W-1:0]  prio;
  logic [NUM_SRC:1]              pend;
  logic [NUM_SRC:1]              lock;
  logic [NUM_TGT-1:0][NUM_SRC:1] en;
  logic [NUM_TGT-1:0][PRIO_W-1:0] thr;

  logic [NUM_TGT-1:0][SRC_W-1:0] winId;
  logic [NUM_TGT-1:0]            winValid;

  logic [SRC_W-1:0] claimId;
  logic             claimFire;
  logic [SRC_W-1:0] cmplId;
  logic             cmplOk;
  logic             cmplFire;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    irqc_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .SRC_W   (SRC_W)
    ) u_arb (
      .clk      (clk),
      .rstN     (rstN),
      .elig     (pend & en[t]),
      .prioVec  (prio),
      .thr      (thr[t]),
      .winId    (winId[t]),
      .winValid (winValid[t])
    );

    // R5: a context at the top minimum can never be eligible
    assert_max_thr_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
      (thr[t] == {PRIO_W{1'b1}}) |-> !irqOut[t]);
  end

  assign claimId   = winId[tgtIdx];
  assign claimFire = strb.claimRe && winValid[tgtIdx];
  assign cmplId    = wdata[SRC_W-1:0];
  assign cmplOk    = (wdata >= 32'd1) && (wdata <= 32'(NUM_SRC)) && en[tgtIdx][cmplId];
  assign cmplFire  = strb.cmplWe && cmplOk;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prio <= '0;
      en   <= '0;
      thr  <= '0;
    end else begin
      if (strb.prioWe) prio[srcIdx] <= wdata[PRIO_W-1:0];
      if (strb.thrWe)  thr[tgtIdx]  <= wdata[PRIO_W-1:0];
      for (int i = 1; i <= NUM_SRC; i++) begin
        if (strb.enWe && (i / 32) == 32'(wordIdx)) en[tgtIdx][i] <= wdata[i % 32];
      end
    end
  end

  // Waiting flags and holds
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
      lock <= '0;
    end else begin
      for (int i = 1; i <= NUM_SRC; i++) begin
        if (claimFire && claimId == SRC_W'(i)) begin
          pend[i] <= 1'b0;
          lock[i] <= 1'b1;
        end else begin
          if (irqIn[i] && !lock[i])                pend[i] <= 1'b1;
          if (cmplFire && cmplId == SRC_W'(i))     lock[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (strb.rdKind)
      RD_PRIO:  rdata = 32'(prio[srcIdx]);
      RD_THR:   rdata = 32'(thr[tgtIdx]);
      RD_CLAIM: rdata = 32'(claimId);
      RD_PEND: begin
        for (int i = 1; i <= NUM_SRC; i++)
          if ((i / 32) == 32'(wordIdx)) rdata[i % 32] = pend[i];
      end
      RD_EN: begin
        for (int i = 1; i <= NUM_SRC; i++)
          if ((i / 32) == 32'(wordIdx)) rdata[i % 32] = en[tgtIdx][i];
      end
      default: rdata = '0;
    endcase
  end

  assign irqOut = winValid;

  assert_claim_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    claimFire |=> (!pend[$past(claimId)] && lock[$past(claimId)]));

  assert_held_no_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((pend & ~$past(pend) & $past(lock)) == '0));

  assert_bad_cmpl_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmplWe && !cmplOk) |=> (lock == $past(lock)));

  assert_empty_claim_inert_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.claimRe && !winValid[tgtIdx]) |=> ((lock == $past(lock)) && ((~pend & $past(pend)) == '0)));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_TGT = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC:1]   irqIn,
  output logic [NUM_TGT-1:0] irqOut
);

  localparam int NUM_WORDS = (NUM_SRC + 32) / 32;
  localparam int SRC_W     = $clog2(NUM_SRC + 1);
  localparam int TGT_W     = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  strobes_t          strb;
  logic [SRC_W-1:0]  srcIdx;
  logic [TGT_W-1:0]  tgtIdx;
  logic [WORD_W-1:0] wordIdx;

  irqc_ctrl #(
    .NUM_SRC (NUM_SRC),
    .NUM_TGT (NUM_TGT),
    .ADDR_W  (ADDR_W),
    .SRC_W   (SRC_W),
    .TGT_W   (TGT_W),
    .WORD_W  (WORD_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .strb    (strb),
    .srcIdx  (srcIdx),
    .tgtIdx  (tgtIdx),
    .wordIdx (wordIdx)
  );

  irqc_datapath #(
    .NUM_SRC (NUM_SRC),
    .NUM_TGT (NUM_TGT),
    .PRIO_W  (PRIO_W),
    .SRC_W   (SRC_W),
    .TGT_W   (TGT_W),
    .WORD_W  (WORD_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .srcIdx  (srcIdx),
    .tgtIdx  (tgtIdx),
    .wordIdx (wordIdx),
    .wdata   (busWdata),
    .irqIn   (irqIn),
    .rdata   (busRdata),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;

  localparam int NS = 31;
  localparam int NT = 2;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NS:1]   irqIn = '0;
  logic [NT-1:0] irqOut;

  irqc_top uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  // Bench-side model
  int          mPrio[32];
  logic [31:0] mEn[NT];
  int          mThr[NT];
  logic [31:0] mPend = '0;
  logic [31:0] mLock = '0;
  logic [31:0] mLines = '0;
  int          nChecks = 0;
  int          nFail = 0;
  bit          done = 1'b0;

  function automatic int prioAddr(int id);  return id; endfunction
  function automatic int enAddr(int t);     return 32'h800 + 32'h20 * t; endfunction
  function automatic int thrAddr(int t);    return 32'h80000 + 32'h400 * t; endfunction
  function automatic int claimAddr(int t);  return 32'h80001 + 32'h400 * t; endfunction

  function automatic int expWin(int t);
    int best = 0;
    int bp = 0;
    for (int id = 1; id <= NS; id++) begin
      if (mPend[id] && mEn[t][id] && mPrio[id] > mThr[t] && mPrio[id] > bp) begin
        best = id;
        bp = mPrio[id];
      end
    end
    return best;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic modelStep(int claimT, int cmplT, int cmplId);
    int w;
    w = (claimT >= 0) ? expWin(claimT) : 0;
    mPend = (mPend | (mLines & ~mLock)) & ~32'd1;
    if (w != 0) begin
      mPend[w] = 1'b0;
      mLock[w] = 1'b1;
    end
    if (cmplT >= 0 && cmplId >= 1 && cmplId <= NS && mEn[cmplT][cmplId]) mLock[cmplId] = 1'b0;
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic busCycle(bit we, int addr, logic [31:0] wd, int claimT, int cmplT, int cmplId,
                          output logic [31:0] rd);
    busSel = 1'b1; busWe = we; busAddr = AW'(addr); busWdata = wd;
    #1 rd = busRdata;
    @(posedge clk);
    modelStep(claimT, cmplT, cmplId);
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      modelStep(-1, -1, 0);
      @(negedge clk);
    end
  endtask

  task automatic setLines(logic [31:0] v);
    mLines = v & ~32'd1;
    irqIn = mLines[NS:1];
  endtask

  task automatic wrPrio(int id, logic [31:0] v);
    logic [31:0] rd;
    busCycle(1'b1, prioAddr(id), v, -1, -1, 0, rd);
    if (id >= 1 && id <= NS) mPrio[id] = int'(v & 32'd7);
  endtask

  task automatic wrEn(int t, logic [31:0] v);
    logic [31:0] rd;
    busCycle(1'b1, enAddr(t), v, -1, -1, 0, rd);
    mEn[t] = v & ~32'd1;
  endtask

  task automatic wrThr(int t, logic [31:0] v);
    logic [31:0] rd;
    busCycle(1'b1, thrAddr(t), v, -1, -1, 0, rd);
    mThr[t] = int'(v & 32'd7);
  endtask

  task automatic complete(int t, int id);
    logic [31:0] rd;
    busCycle(1'b1, claimAddr(t), 32'(id), -1, t, id, rd);
  endtask

  task automatic rdChk(int addr, logic [31:0] exp, string req);
    logic [31:0] rd;
    busCycle(1'b0, addr, '0, -1, -1, 0, rd);
    chk(rd == exp, req, rd, exp);
  endtask

  task automatic claimChk(int t, string req, output int got);
    logic [31:0] rd;
    int e;
    e = expWin(t);
    busCycle(1'b0, claimAddr(t), '0, t, -1, 0, rd);
    chk(rd == 32'(e), req, rd, 32'(e));
    got = int'(rd);
  endtask

  task automatic irqChk(string req);
    logic [NT-1:0] e;
    for (int t = 0; t < NT; t++) e[t] = (expWin(t) != 0);
    chk(irqOut == e, req, 32'(irqOut), 32'(e));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog R1: actual hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int got;
    int lastGot;
    for (int i = 0; i < 32; i++) mPrio[i] = 0;
    for (int t = 0; t < NT; t++) begin mEn[t] = '0; mThr[t] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(irqOut == '0, "R1 irq outputs", 32'(irqOut), 32'h0);
    for (int id = 1; id <= NS; id++) rdChk(prioAddr(id), 32'h0, "R1 level after reset");
    rdChk(32'h400, 32'h0, "R1 waiting word after reset");
    for (int t = 0; t < NT; t++) begin
      rdChk(enAddr(t), 32'h0, "R1 mask after reset");
      rdChk(thrAddr(t), 32'h0, "R1 minimum after reset");
      claimChk(t, "R1 claim after reset", got);
    end

    // R2: level registers
    for (int id = 0; id <= NS; id++) wrPrio(id, 32'hFFFF_FFF8 | 32'((id * 5 + 3) % 8));
    for (int id = 1; id <= NS; id++) rdChk(prioAddr(id), 32'(mPrio[id]), "R2 level readback");
    rdChk(0, 32'h0, "R2 word 0 not a register");

    // R4: masks
    wrEn(0, 32'hAAAA_AAAB);
    wrEn(1, 32'h5555_5555);
    rdChk(enAddr(0), 32'hAAAA_AAAA, "R4 mask ctx0");
    rdChk(enAddr(1), 32'h5555_5554, "R4 mask ctx1");

    // R9: unmapped addresses
    rdChk(32'h401, 32'h0, "R9 after waiting word");
    rdChk(enAddr(2), 32'h0, "R9 mask of missing ctx");
    rdChk(32'h801, 32'h0, "R9 second mask word");
    rdChk(32'h80002, 32'h0, "R9 ctx gap");
    rdChk(thrAddr(2), 32'h0, "R9 missing ctx minimum");
    rdChk(32'h3FF, 32'h0, "R9 below waiting word");

    // R3: waiting capture, read-only, sticky
    setLines(32'h0F0F_F0F1);
    tick(1);
    rdChk(32'h400, 32'h0F0F_F0F0, "R3 waiting capture");
    irqChk("R5 outputs with mixed masks");
    begin
      logic [31:0] rd;
      busCycle(1'b1, 32'h400, 32'h0, -1, -1, 0, rd);
    end
    rdChk(32'h400, mPend, "R3 waiting word write ignored");
    setLines(32'h0);
    tick(2);
    rdChk(32'h400, 32'h0F0F_F0F0, "R3 flags stay after line drop");

    // R5: sweep of minimums on both contexts
    for (int th = 0; th < 8; th++) begin
      wrThr(0, 32'(th));
      wrThr(1, 32'(7 - th) | 32'hFFFF_FF00);
      rdChk(thrAddr(0), 32'(th), "R5 minimum readback");
      irqChk("R5 output vs minimum");
    end
    wrThr(0, 0);
    wrThr(1, 0);

    // R6/R7: drain both contexts, completing each
    for (int k = 0; k < 40; k++) begin
      claimChk(k % 2, "R6 claim order", got);
      if (got != 0) complete(k % 2, got);
    end
    claimChk(0, "R10 empty claim", got);
    rdChk(32'h400, mPend, "R10 waiting unchanged after empty claim");

    // Per-source sweep, two level patterns
    for (int pat = 0; pat < 2; pat++) begin
      for (int id = 1; id <= NS; id++)
        wrPrio(id, 32'((pat == 0) ? (id * 3) % 8 : (7 - (id % 4))));
      wrEn(0, 32'hFFFF_FFFF);
      wrEn(1, 32'h3333_3333);
      wrThr(1, 32'(pat + 1));
      for (int id = 1; id <= NS; id++) begin
        setLines(32'h1 << id);
        tick(1);
        setLines(32'h0);
        irqChk("R5 single line output");
        claimChk(id % 2, "R6 single line claim", got);
        if (got != 0) complete(id % 2, got);
        claimChk((id + 1) % 2, "R6 other context", got);
        if (got != 0) complete((id + 1) % 2, got);
      end
    end

    // R7/R8: hold-off with lines held high
    for (int id = 1; id <= NS; id++) wrPrio(id, 32'((id * 3) % 8));
    wrEn(0, 32'hFFFF_FFFE);
    wrEn(1, 32'hFFFF_FFFE);
    wrThr(0, 0);
    wrThr(1, 0);
    setLines(32'hFFFF_FFFE);
    tick(1);
    lastGot = 1;
    for (int k = 0; k < 40; k++) begin
      claimChk(k % 2, "R6 drain without completion", got);
    end
    rdChk(32'h400, mPend, "R7 held sources stay clear");
    irqChk("R7 outputs after drain");
    tick(5);
    rdChk(32'h400, mPend, "R7 held with lines high");
    // 7 is held (level 5 > 0); remove it from ctx1 mask
    wrEn(1, 32'hFFFF_FF7E);
    complete(0, 0);
    complete(0, 40);
    complete(1, 7);
    tick(2);
    rdChk(32'h400, mPend, "R8 invalid completions ignored");
    chk(mPend[7] == 1'b0, "R8 source 7 still held", 32'(mPend[7]), 32'h0);
    complete(0, 7);
    tick(1);
    rdChk(32'h400, mPend, "R8 valid completion releases");
    chk(mPend[7] == 1'b1, "R8 model source 7 waiting", 32'(mPend[7]), 32'h1);
    claimChk(1, "R4 ctx1 does not see masked 7", got);
    claimChk(0, "R7 ctx0 reclaims 7", got);
    chk(got == 7, "R7 reclaimed ID", 32'(got), 32'd7);
    setLines(32'h0);
    tick(1);
    irqChk("R5 final outputs");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule